// File: doc/BRIEF.md
# Dual-Group Conversion Trigger Selector

This block turns a shared bus of asynchronous event lines into conversion start strobes for two independent channel groups of a data converter: an ordinary group and a preempted group. Each group picks one event line with its own select code, decides which transitions of that line count as a trigger with its own polarity setting, and can also be started from software with a self-clearing trigger bit. The output of each group is a start strobe that feeds that group's conversion sequencer, which lies outside this block.

The whole event bus first passes through one shared synchronizer. Each group then picks its line, compares it with the value seen one cycle earlier, and qualifies the transition with its polarity setting. Two select codes are held back as reserved and never produce an external trigger. When a group's select code or polarity setting changes, that cycle's comparison is discarded, so reconfiguring cannot create a trigger. A software request is latched into a pending bit that drives the strobe for one cycle and then clears itself. It works whatever the polarity or select setting is.

Top module: `adc_trig_sel`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both start strobes and both software-pending bits are low.
- R2: With polarity code 01 (rising), a 0-to-1 change of the selected event line that is sampled at clock edge k makes the group's start strobe high for exactly one cycle: the cycle between edges k+1 and k+2. A 1-to-0 change gives no strobe.
- R3: With polarity code 10 (falling), a 1-to-0 change of the selected line gives the same one-cycle strobe with the same timing as in R2. A 0-to-1 change gives none.
- R4: With polarity code 11 (both), either change of the selected line gives the one-cycle strobe with the timing of R2.
- R5: With polarity code 00 (disabled), no change of any event line produces a start strobe for that group.
- R6: Select codes 29 (11101) and 31 (11111) are reserved. With either code selected, no event line produces a start strobe for that group.
- R7: Changes on event lines other than the selected one (select code = bit index of the bus) have no effect on the group's start strobe.
- R8: The two groups are independent: an event that triggers one group, or that group's software request, never produces a strobe on the other group's output.
- R9: A one-cycle software request sampled at edge k sets the group's pending bit and makes its start strobe high in the cycle after edge k. Both fall at edge k+1. This works with any polarity and any select code, including reserved ones.
- R10: A change of a group's select code or polarity setting never produces a start strobe by itself, even when the newly selected line holds a different level from the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_bus | input | EVT_W (32) | Asynchronous external event lines |
| ord_sel | input | log2(EVT_W) (5) | Ordinary group source select code |
| ord_pol | input | 2 | Ordinary group polarity: 00 off, 01 rising, 10 falling, 11 both |
| ord_sw_req | input | 1 | Ordinary group software trigger write pulse |
| pre_sel | input | log2(EVT_W) (5) | Preempted group source select code |
| pre_pol | input | 2 | Preempted group polarity, same encoding as ord_pol |
| pre_sw_req | input | 1 | Preempted group software trigger write pulse |
| ord_start | output | 1 | Ordinary group conversion start strobe |
| ord_sw_pend | output | 1 | Ordinary group software trigger bit, self-clearing |
| pre_start | output | 1 | Preempted group conversion start strobe |
| pre_sw_pend | output | 1 | Preempted group software trigger bit, self-clearing |

## Verification
The assertions check the following on every cycle for both groups: a disabled polarity or a reserved select code never lets a strobe through without a software request, a reconfiguration cycle never strobes, and the software pending bit sets after each request and then clears. The exact two-cycle latency of external triggers, the choice between rising, falling and both edges, and the blindness to unselected lines can only be shown by the bench. The bench sweeps every select code under every polarity for both transition directions on each group. It also watches the other group's output during each sweep.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

   // Polarity code shared by both trigger groups
   typedef enum logic [1:0] {
      POL_OFF  = 2'b00,
      POL_RISE = 2'b01,
      POL_FALL = 2'b10,
      POL_BOTH = 2'b11
   } trig_pol_e;

   localparam int unsigned NUM_GROUPS = 2;

endpackage

// File: rtl/adc_evt_sync.sv
// Multi-stage synchronizer for a bus of asynchronous event lines.
// STAGES = 0 gives a bypass for sources that are already synchronous.
module adc_evt_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] q_sync
);

   generate
      if (!(STAGES == 0 || STAGES >= 2)) begin : g_bad_stages
         $error("adc_evt_sync: STAGES must be 0 or at least 2");
      end

      if (STAGES == 0) begin : g_bypass
         assign q_sync = d_async;
      end else begin : g_chain
         logic [W-1:0] stage_q [STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= '0;
            else        stage_q[0] <= d_async;
         end

         for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end

         assign q_sync = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/adc_trig_path.sv
// One group's trigger path: source pick, edge qualification,
// reconfiguration guard and self-clearing software request.
module adc_trig_path
   import adc_trig_pkg::*;
#(
   parameter int unsigned    EVT_W     = 32,
   parameter int unsigned    SEL_W     = 5,
   parameter logic [EVT_W-1:0] RSVD_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] evt_s,
   input  logic [SEL_W-1:0] sel,
   input  logic [1:0]       pol,
   input  logic             sw_req,
   output logic             start,
   output logic             sw_pend
);

   logic             code_rsvd;
   logic             cur_lvl;
   logic             prev_lvl;
   logic [SEL_W-1:0] sel_q;
   trig_pol_e        pol_q;
   trig_pol_e        pol_now;
   logic             cfg_moved;
   logic             hit;
   logic             ext_fire;

   assign pol_now   = trig_pol_e'(pol);
   assign code_rsvd = RSVD_MASK[sel];
   assign cur_lvl   = evt_s[sel] & ~code_rsvd;
   assign cfg_moved = (sel != sel_q) || (pol_now != pol_q);

   always_comb begin
      unique case (pol_now)
         POL_RISE: hit = cur_lvl & ~prev_lvl;
         POL_FALL: hit = ~cur_lvl & prev_lvl;
         POL_BOTH: hit = cur_lvl ^ prev_lvl;
         default:  hit = 1'b0;
      endcase
   end

   assign ext_fire = hit & ~cfg_moved & ~code_rsvd;

   // History and configuration shadows: a config change reloads the
   // history with the new source level, so the next compare is clean.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_lvl <= 1'b0;
         sel_q    <= '0;
         pol_q    <= POL_OFF;
      end else begin
         prev_lvl <= cur_lvl;
         sel_q    <= sel;
         pol_q    <= pol_now;
      end
   end

   // Software trigger bit: set by a write, cleared once its strobe is out
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sw_pend <= 1'b0;
      else if (sw_req)  sw_pend <= 1'b1;
      else if (start)   sw_pend <= 1'b0;
   end

   assign start = ext_fire | sw_pend;

endmodule

// File: rtl/adc_trig_sel.sv
// Dual-group conversion trigger selector (top).
module adc_trig_sel
   import adc_trig_pkg::*;
#(
   parameter int unsigned      EVT_W       = 32,
   parameter int unsigned      SYNC_STAGES = 2,
   parameter logic [EVT_W-1:0] RSVD_MASK   = 32'hA000_0000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [EVT_W-1:0]         evt_bus,
   input  logic [$clog2(EVT_W)-1:0] ord_sel,
   input  logic [1:0]               ord_pol,
   input  logic                     ord_sw_req,
   input  logic [$clog2(EVT_W)-1:0] pre_sel,
   input  logic [1:0]               pre_pol,
   input  logic                     pre_sw_req,
   output logic                     ord_start,
   output logic                     ord_sw_pend,
   output logic                     pre_start,
   output logic                     pre_sw_pend
);

   localparam int unsigned SEL_W = $clog2(EVT_W);

   generate
      if (EVT_W < 2 || (1 << SEL_W) != EVT_W) begin : g_bad_width
         $error("adc_trig_sel: EVT_W must be a power of two, at least 2");
      end
   endgenerate

   logic [EVT_W-1:0] evt_s;
   logic [SEL_W-1:0] grp_sel   [NUM_GROUPS];
   logic [1:0]       grp_pol   [NUM_GROUPS];
   logic             grp_req   [NUM_GROUPS];
   logic             grp_start [NUM_GROUPS];
   logic             grp_pend  [NUM_GROUPS];

   adc_evt_sync #(
      .W      (EVT_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (evt_bus),
      .q_sync  (evt_s)
   );

   // Group 0 = ordinary, group 1 = preempted
   assign grp_sel[0] = ord_sel;
   assign grp_pol[0] = ord_pol;
   assign grp_req[0] = ord_sw_req;
   assign grp_sel[1] = pre_sel;
   assign grp_pol[1] = pre_pol;
   assign grp_req[1] = pre_sw_req;

   generate
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
         adc_trig_path #(
            .EVT_W     (EVT_W),
            .SEL_W     (SEL_W),
            .RSVD_MASK (RSVD_MASK)
         ) u_path (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_s   (evt_s),
            .sel     (grp_sel[g]),
            .pol     (grp_pol[g]),
            .sw_req  (grp_req[g]),
            .start   (grp_start[g]),
            .sw_pend (grp_pend[g])
         );
      end
   endgenerate

   assign ord_start   = grp_start[0];
   assign ord_sw_pend = grp_pend[0];
   assign pre_start   = grp_start[1];
   assign pre_sw_pend = grp_pend[1];

endmodule

// File: rtl/adc_trig_sel_chk.sv
// Property checker bound to the trigger selector.
module adc_trig_sel_chk #(
   parameter int unsigned      EVT_W     = 32,
   parameter logic [EVT_W-1:0] RSVD_MASK = 32'hA000_0000
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [$clog2(EVT_W)-1:0] ord_sel,
   input logic [1:0]               ord_pol,
   input logic                     ord_sw_req,
   input logic [$clog2(EVT_W)-1:0] pre_sel,
   input logic [1:0]               pre_pol,
   input logic                     pre_sw_req,
   input logic                     ord_start,
   input logic                     ord_sw_pend,
   input logic                     pre_start,
   input logic                     pre_sw_pend
);

   // R5: disabled polarity lets only software requests through
   p_off_quiet_ord_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ord_pol == 2'b00 && !ord_sw_pend) |-> !ord_start);
   p_off_quiet_pre_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_pol == 2'b00 && !pre_sw_pend) |-> !pre_start);

   // R6: reserved select codes never trigger externally
   p_rsvd_quiet_ord_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (RSVD_MASK[ord_sel] && !ord_sw_pend) |-> !ord_start);
   p_rsvd_quiet_pre_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (RSVD_MASK[pre_sel] && !pre_sw_pend) |-> !pre_start);

   // R9: a request sets the pending bit and strobes the next cycle
   p_sw_fire_ord_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ord_sw_req |=> (ord_sw_pend && ord_start));
   p_sw_fire_pre_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pre_sw_req |=> (pre_sw_pend && pre_start));

   // R9: the pending bit clears itself when no new request arrives
   p_sw_clear_ord_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ord_sw_pend && !ord_sw_req) |=> !ord_sw_pend);
   p_sw_clear_pre_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_sw_pend && !pre_sw_req) |=> !pre_sw_pend);

   // R10: a reconfiguration cycle never strobes on its own
   p_cfg_guard_ord_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((ord_sel != $past(ord_sel) || ord_pol != $past(ord_pol)) && !ord_sw_pend)
      |-> !ord_start);
   p_cfg_guard_pre_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((pre_sel != $past(pre_sel) || pre_pol != $past(pre_pol)) && !pre_sw_pend)
      |-> !pre_start);

endmodule

bind adc_trig_sel adc_trig_sel_chk #(
   .EVT_W     (EVT_W),
   .RSVD_MASK (RSVD_MASK)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ord_sel     (ord_sel),
   .ord_pol     (ord_pol),
   .ord_sw_req  (ord_sw_req),
   .pre_sel     (pre_sel),
   .pre_pol     (pre_pol),
   .pre_sw_req  (pre_sw_req),
   .ord_start   (ord_start),
   .ord_sw_pend (ord_sw_pend),
   .pre_start   (pre_start),
   .pre_sw_pend (pre_sw_pend)
);

// File: tb/adc_trig_sel_bench.sv
`timescale 1ns/1ps
module adc_trig_sel_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] evt = '0;
   logic [4:0]  sel [2];
   logic [1:0]  pol [2];
   logic        req [2];
   logic        start [2];
   logic        pend [2];
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   adc_trig_sel u_adc_trig_sel (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_bus     (evt),
      .ord_sel     (sel[0]),
      .ord_pol     (pol[0]),
      .ord_sw_req  (req[0]),
      .pre_sel     (sel[1]),
      .pre_pol     (pol[1]),
      .pre_sw_req  (req[1]),
      .ord_start   (start[0]),
      .ord_sw_pend (pend[0]),
      .pre_start   (start[1]),
      .pre_sw_pend (pend[1])
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   function automatic bit is_rsvd(input int s);
      return (s == 29) || (s == 31);
   endfunction

   // Sweep one group: select s, polarity p, direction up (1 = rising)
   task automatic run_edge(input int g, input int s, input int p, input bit up);
      int  o;
      bit  fire;
      string tag;
      o = 1 - g;
      sel[g] = 5'(s); pol[g] = 2'(p);
      sel[o] = 5'((s + 7) % 32); pol[o] = 2'b11;
      evt = '0;
      evt[s] = ~up;
      repeat (6) step();
      fire = !is_rsvd(s) && ((up && p[0]) || (!up && p[1]));
      case (p)
         0: tag = "R5";
         1: tag = "R2";
         2: tag = "R3";
         default: tag = "R4";
      endcase
      if (is_rsvd(s)) tag = "R6";
      evt[s] = up;
      for (int k = 1; k <= 5; k++) begin
         step();
         check(tag, int'(start[g]), (fire && k == 2) ? 1 : 0);
         check("R8", int'(start[o]), 0);
      end
   endtask

   // R7: every line but the selected one toggles
   task automatic run_others(input int g, input int s);
      sel[g] = 5'(s); pol[g] = 2'b11;
      evt = '0;
      repeat (6) step();
      evt = ~(32'h1 << s);
      for (int k = 1; k <= 5; k++) begin
         step();
         check("R7", int'(start[g]), 0);
      end
   endtask

   // R10: switch select to a line at another level, no strobe
   task automatic run_cfg(input int g, input int from_s, input int to_s,
                          input int from_p, input int to_p);
      sel[g] = 5'(from_s); pol[g] = 2'(from_p);
      repeat (6) step();
      sel[g] = 5'(to_s); pol[g] = 2'(to_p);
      for (int k = 1; k <= 5; k++) begin
         step();
         check("R10", int'(start[g]), 0);
      end
   endtask

   // R9: software request under any polarity/select
   task automatic run_sw(input int g, input int s, input int p);
      int o;
      o = 1 - g;
      sel[g] = 5'(s); pol[g] = 2'(p);
      pol[o] = 2'b00;
      repeat (6) step();
      req[g] = 1'b1;
      step();
      req[g] = 1'b0;
      check("R9", int'(start[g]), 1);
      check("R9", int'(pend[g]), 1);
      check("R8", int'(start[o]), 0);
      step();
      check("R9", int'(start[g]), 0);
      check("R9", int'(pend[g]), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int g = 0; g < 2; g++) begin
         sel[g] = 5'd3; pol[g] = 2'b11; req[g] = 1'b0;
      end
      // R1: reset state
      repeat (3) step();
      for (int g = 0; g < 2; g++) begin
         check("R1", int'(start[g]), 0);
         check("R1", int'(pend[g]), 0);
      end
      rst_n = 1'b1;
      step();
      for (int g = 0; g < 2; g++) begin
         check("R1", int'(start[g]), 0);
         check("R1", int'(pend[g]), 0);
      end

      // R2..R6, R8: full sweep over both groups
      for (int g = 0; g < 2; g++)
         for (int s = 0; s < 32; s++)
            for (int p = 0; p < 4; p++) begin
               run_edge(g, s, p, 1'b1);
               run_edge(g, s, p, 1'b0);
            end

      // R7
      for (int g = 0; g < 2; g++)
         for (int s = 0; s < 32; s++)
            run_others(g, s);

      // R10: line 3 high, line 4 low
      for (int g = 0; g < 2; g++) begin
         evt = 32'h0000_0008;
         run_cfg(g, 4, 3, 3, 3);
         run_cfg(g, 3, 4, 3, 3);
         run_cfg(g, 29, 3, 1, 1);
         run_cfg(g, 3, 3, 0, 3);
         run_cfg(g, 4, 3, 2, 1);
      end

      // R9
      evt = '0;
      for (int g = 0; g < 2; g++)
         for (int p = 0; p < 4; p++) begin
            run_sw(g, 29, p);
            run_sw(g, 31, p);
            run_sw(g, 5, p);
         end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule